// File: doc/BRIEF.md
# Dual-Port Memory with Collision Busy Arbiter

This block is a true dual-port synchronous RAM with two independent ports, left and right. Each port has a chip enable, an address, a write enable, write data and registered read data. A collision arbiter watches both ports. When both ports are enabled at the same address in the same cycle, one port is allowed to proceed and the other is flagged busy. The flagged port's write is blocked inside the block.

A mode input selects how the busy pins behave. In master mode the arbiter drives an active-low busy output for each port. In slave mode the arbiter is disabled and its busy outputs stay inactive. Each port then has an active-low inhibit input that gates that port's writes. Several instances can therefore share one arbitration decision when they are ganged for width expansion. Wiring the master's busy outputs to the slaves' inhibit inputs gives this sharing. A combined active-high collision flag is also provided as an interrupt source.

Top module: `dpram_busy_arb`

## Requirements
- R1: In master mode, a port's busy output is low only when both chip enables are high and both addresses are equal in that cycle.
- R2: Arbitration ignores the write enables. A read/read collision raises busy exactly like a write/write collision.
- R3: At most one busy output is low at any time. On a fresh collision, where neither port held the address alone in the previous cycle, the left port wins and the right port's busy goes low.
- R4: A write from the port whose busy output is low does not change memory.
- R5: A port "holds" an address in a cycle when it was enabled at that same address in the previous cycle and its busy was high then. If the right port holds the address and the left port does not, the left port gets busy.
- R6: In slave mode (master_mode=0), both busy outputs stay high and the collision flag stays low.
- R7: In slave mode, a high inhibit input gives normal writes for that port, and a low inhibit input blocks every write from that port. If both ports write the same address in one cycle, the left port's data is stored.
- R8: Reads are never blocked. When ce is high, rdata shows the addressed word after the next rising edge, as it was before any write at that edge. When ce is low, rdata holds its value. Reset clears rdata to 0.
- R9: The collision output equals the OR of the two active-high busy indications.
- R10: Busy and the collision flag are combinational and appear in the same cycle as the colliding addresses, before the write edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | 1 = arbiter drives busy, 0 = slave (inhibit inputs gate writes) |
| l_ce | input | 1 | Left chip enable |
| l_addr | input | ADDR_W | Left address |
| l_we | input | 1 | Left write enable |
| l_wdata | input | DATA_W | Left write data |
| l_rdata | output | DATA_W | Left read data (registered) |
| l_busy_n | output | 1 | Left busy, active low (master mode) |
| l_inhibit_n | input | 1 | Left write inhibit, active low (slave mode) |
| r_ce | input | 1 | Right chip enable |
| r_addr | input | ADDR_W | Right address |
| r_we | input | 1 | Right write enable |
| r_wdata | input | DATA_W | Right write data |
| r_rdata | output | DATA_W | Right read data (registered) |
| r_busy_n | output | 1 | Right busy, active low (master mode) |
| r_inhibit_n | input | 1 | Right write inhibit, active low (slave mode) |
| collide | output | 1 | Active-high collision flag |

## Verification
The assertions check on every cycle that busy is mutually exclusive, that busy only appears with a real address match, and that the holder of an address keeps priority. They also check that a blocked port never produces a write strobe, in either mode. The bench's scenarios are needed to show what actually lands in memory. Examples are a losing write that leaves the old word in place, reads that return pre-write data during a collision, and the left-wins rule for simultaneous slave writes. A behavioural reference model, compared on every clock over a random stream of accesses to a few addresses, covers long sequences in which ownership of an address passes from one port to the other.

// File: rtl/dpb_pkg.sv
package dpb_pkg;
  typedef enum logic {WIN_LEFT = 1'b0, WIN_RIGHT = 1'b1} side_e;
endpackage

// File: rtl/dpb_arbiter.sv
module dpb_arbiter #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  output logic              l_busy,
  output logic              r_busy
);
  import dpb_pkg::*;

  function automatic logic same_slot(logic ca, logic cb,
                                     logic [ADDR_W-1:0] a, logic [ADDR_W-1:0] b);
    return ca && cb && (a == b);
  endfunction

  logic              l_held_q, r_held_q;
  logic [ADDR_W-1:0] l_addr_q, r_addr_q;
  logic              hit, l_holds, r_holds;
  side_e             winner;

  assign hit     = same_slot(l_ce, r_ce, l_addr, r_addr);
  assign l_holds = l_held_q && (l_addr_q == l_addr);
  assign r_holds = r_held_q && (r_addr_q == r_addr);
  assign winner  = (r_holds && !l_holds) ? WIN_RIGHT : WIN_LEFT;

  assign l_busy = master_mode && hit && (winner == WIN_RIGHT);
  assign r_busy = master_mode && hit && (winner == WIN_LEFT);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_held_q <= 1'b0;
      r_held_q <= 1'b0;
      l_addr_q <= '0;
      r_addr_q <= '0;
    end else begin
      l_held_q <= l_ce && !l_busy;
      r_held_q <= r_ce && !r_busy;
      l_addr_q <= l_addr;
      r_addr_q <= r_addr;
    end
  end

  a_r3_exclusive_busy: assert property (@(posedge clk) disable iff (!rst_n)
    !(l_busy && r_busy));

  a_r1_busy_needs_match: assert property (@(posedge clk) disable iff (!rst_n)
    (l_busy || r_busy) |-> (l_ce && r_ce && l_addr == r_addr));

  a_r6_slave_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !master_mode |-> (!l_busy && !r_busy));

  // R5: right sole holder keeps the slot when left arrives
  a_r5_holder_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(r_ce && !r_busy && !(l_ce && l_addr == r_addr)) &&
     master_mode && l_ce && r_ce && l_addr == r_addr && r_addr == $past(r_addr))
    |-> l_busy);
endmodule

// File: rtl/dpb_write_gate.sv
module dpb_write_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic master_mode,
  input  logic ce,
  input  logic we,
  input  logic arb_busy,
  input  logic inhibit_n,
  output logic wr_en
);
  logic blocked;
  assign blocked = master_mode ? arb_busy : !inhibit_n;
  assign wr_en   = ce && we && !blocked;

  a_r4_busy_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (master_mode && arb_busy) |-> !wr_en);

  a_r7_inhibit_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (!master_mode && !inhibit_n) |-> !wr_en);
endmodule

// File: rtl/dpb_mem.sv
module dpb_mem #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_wr,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_wr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata
);
  localparam int DEPTH = 1 << ADDR_W;
  logic [DATA_W-1:0] mem [DEPTH];

  // right first, so left wins a same-address double write
  always_ff @(posedge clk) begin
    if (r_wr) mem[r_addr] <= r_wdata;
    if (l_wr) mem[l_addr] <= l_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      l_rdata <= '0;
      r_rdata <= '0;
    end else begin
      if (l_ce) l_rdata <= mem[l_addr];
      if (r_ce) r_rdata <= mem[r_addr];
    end
  end

  a_r8_hold_rdata: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(l_ce)) |-> $stable(l_rdata));
endmodule

// File: rtl/dpram_busy_arb.sv
module dpram_busy_arb #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              master_mode,
  input  logic              l_ce,
  input  logic [ADDR_W-1:0] l_addr,
  input  logic              l_we,
  input  logic [DATA_W-1:0] l_wdata,
  output logic [DATA_W-1:0] l_rdata,
  output logic              l_busy_n,
  input  logic              l_inhibit_n,
  input  logic              r_ce,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic              r_we,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  output logic              r_busy_n,
  input  logic              r_inhibit_n,
  output logic              collide
);
  logic l_busy, r_busy, l_wr, r_wr;

  dpb_arbiter #(.ADDR_W(ADDR_W)) u_arb (
    .clk, .rst_n, .master_mode,
    .l_ce, .l_addr, .r_ce, .r_addr,
    .l_busy, .r_busy
  );

  dpb_write_gate u_gate_l (
    .clk, .rst_n, .master_mode, .ce(l_ce), .we(l_we),
    .arb_busy(l_busy), .inhibit_n(l_inhibit_n), .wr_en(l_wr)
  );

  dpb_write_gate u_gate_r (
    .clk, .rst_n, .master_mode, .ce(r_ce), .we(r_we),
    .arb_busy(r_busy), .inhibit_n(r_inhibit_n), .wr_en(r_wr)
  );

  dpb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk, .rst_n,
    .l_ce, .l_addr, .l_wr, .l_wdata, .l_rdata,
    .r_ce, .r_addr, .r_wr, .r_wdata, .r_rdata
  );

  assign l_busy_n = !l_busy;
  assign r_busy_n = !r_busy;
  assign collide  = l_busy || r_busy;

  a_r9_collide_or: assert property (@(posedge clk) disable iff (!rst_n)
    collide == (!l_busy_n || !r_busy_n));
endmodule

// File: tb/dpram_busy_arb_bench.sv
module dpram_busy_arb_bench;
  localparam int AW = 6;
  localparam int DW = 8;

  logic clk = 0, rst_n = 0, master_mode = 1;
  logic l_ce = 0, l_we = 0, r_ce = 0, r_we = 0;
  logic l_inhibit_n = 1, r_inhibit_n = 1;
  logic [AW-1:0] l_addr = 0, r_addr = 0;
  logic [DW-1:0] l_wdata = 0, r_wdata = 0;
  logic [DW-1:0] l_rdata, r_rdata;
  logic l_busy_n, r_busy_n, collide;

  int checks = 0, failures = 0;
  int mdl [64];
  int exp_l_rd = 0, exp_r_rd = 0;
  int l_own = -1, r_own = -1;

  always #5 clk = ~clk;

  dpram_busy_arb #(.ADDR_W(AW), .DATA_W(DW)) u_dpram_busy_arb (.*);

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic step(bit m, bit lc, int la, bit lw, int ld, bit li,
                      bit rc, int ra, bit rw, int rd, bit ri, string req);
    bit hit, lb, rb, lwr, rwr;
    @(negedge clk);
    master_mode = m; l_ce = lc; l_addr = la[AW-1:0]; l_we = lw;
    l_wdata = ld[DW-1:0]; l_inhibit_n = li;
    r_ce = rc; r_addr = ra[AW-1:0]; r_we = rw; r_wdata = rd[DW-1:0];
    r_inhibit_n = ri;
    #1;
    hit = lc && rc && (la == ra);
    lb = 0; rb = 0;
    if (m && hit) begin
      if (r_own == ra && l_own != la) lb = 1; else rb = 1;
    end
    chk({req, "/R1 l_busy_n"}, l_busy_n, !lb);
    chk({req, "/R3 r_busy_n"}, r_busy_n, !rb);
    chk({req, "/R9 collide"}, collide, lb || rb);
    lwr = lc && lw && (m ? !lb : li);
    rwr = rc && rw && (m ? !rb : ri);
    @(posedge clk); #1;
    if (lc) exp_l_rd = mdl[la];
    if (rc) exp_r_rd = mdl[ra];
    if (rwr) mdl[ra] = rd;
    if (lwr) mdl[la] = ld;
    l_own = (lc && !lb) ? la : -1;
    r_own = (rc && !rb) ? ra : -1;
    chk({req, "/R8 l_rdata"}, l_rdata, exp_l_rd);
    chk({req, "/R8 r_rdata"}, r_rdata, exp_r_rd);
  endtask

  task automatic idle(bit m);
    step(m, 0,0,0,0,1, 0,0,0,0,1, "idle");
  endtask

  initial begin
    #1_000_000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 64; i++) mdl[i] = 0;
    repeat (3) @(posedge clk);
    #1;
    chk("R8 reset l_rdata", l_rdata, 0);
    chk("R8 reset r_rdata", r_rdata, 0);
    chk("R1 reset l_busy_n", l_busy_n, 1);
    @(negedge clk); rst_n = 1;
    // preload all words with non-colliding writes
    for (int a = 0; a < 64; a += 2)
      step(1, 1,a,1,a+1,1, 1,a+1,1,a+101,1, "R1 preload");
    // R3/R4: write-write collision, left wins, right write lost
    idle(1);
    step(1, 1,5,1,200,1, 1,5,1,77,1, "R4 wr-wr");
    idle(1);
    step(1, 1,5,0,0,1, 0,0,0,0,1, "R4 readback");
    chk("R4 mem[5] left value", l_rdata, 200);
    // R2: read-read collision still busy
    idle(1);
    step(1, 1,9,0,0,1, 1,9,0,0,1, "R2 rd-rd");
    // R5: right holds, left arrives -> left busy, right write lands
    idle(1);
    step(1, 0,0,0,0,1, 1,12,0,0,1, "R5 r alone");
    step(1, 1,12,1,55,1, 1,12,1,66,1, "R5 holder");
    step(1, 1,12,1,56,1, 1,12,1,67,1, "R5 continue");
    idle(1);
    step(1, 1,12,0,0,1, 0,0,0,0,1, "R5 readback");
    chk("R5 mem[12] right value", l_rdata, 67);
    // R10/R8: read-before-write across ports during collision
    idle(1);
    step(1, 1,20,1,9,1, 1,20,0,0,1, "R10 rbw");
    // R6/R7: slave mode
    idle(0);
    step(0, 1,30,1,31,1, 1,30,1,32,1, "R6 slave both");
    step(0, 1,30,0,0,1, 0,0,0,0,1, "R7 readback");
    chk("R7 left wins same addr", l_rdata, 31);
    step(0, 1,31,1,90,0, 1,32,1,91,0, "R7 inhibit low");
    step(0, 1,32,1,92,1, 1,31,0,0,0, "R7 mixed");
    step(0, 1,31,0,0,0, 1,32,0,0,0, "R8 read inhibited");
    // random master stream on few addresses
    for (int n = 0; n < 400; n++)
      step(1, 1'($urandom_range(0,1)), $urandom_range(40,43), 1'($urandom_range(0,1)),
           $urandom_range(0,255), 1,
           1'($urandom_range(0,1)), $urandom_range(40,43), 1'($urandom_range(0,1)),
           $urandom_range(0,255), 1, "R5 random");
    for (int n = 0; n < 100; n++)
      step(0, 1'($urandom_range(0,1)), $urandom_range(40,43), 1'($urandom_range(0,1)),
           $urandom_range(0,255), 1'($urandom_range(0,1)),
           1'($urandom_range(0,1)), $urandom_range(40,43), 1'($urandom_range(0,1)),
           $urandom_range(0,255), 1'($urandom_range(0,1)), "R7 random");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule